// File: doc/BRIEF.md
# Processor Activity Watchdog with Edge Restart

This block watches a processor's activity signal and raises an alarm when that signal stops moving. Every change of level on the activity input, whether low-to-high or high-to-low, restarts a timeout counter. If the counter runs a full timeout period without seeing a change, the active-low alarm output is pulled low. The alarm stays low until the activity input moves again or the system enters reset. The input first passes through a synchronizer, so it may come from any clock domain.

The counter is held at zero while the system is in reset and while the activity input is flagged as undriven. When the input is undriven, the alarm is therefore never raised by the timer. A supply-good flag from an external comparator overrides everything: when the flag is low, the alarm output goes low in the same cycle, whatever the timer holds. With a floating activity input, the output works purely as a low-supply indicator. The timeout is a parameter in clock cycles. The default is 1.6 s at 50 MHz, and a bench can scale it down.

Top module: `wdog_supervisor`

## Requirements
- R1: With the counter not held, `supply_ok` high and no level change on `kick_in`, `wdog_n` goes low right after the TIMEOUT_CYC-th rising clock edge that follows the last edge that cleared the counter, and it is still high after the edge before that.
- R2: A low-to-high change on `kick_in` clears the counter and restarts the timeout.
- R3: A high-to-low change on `kick_in` clears the counter and restarts the timeout.
- R4: While `sys_hold` is high, the counter is held at zero and `wdog_n` equals `supply_ok`, for any length of time. Counting starts from zero on the first clock edge after `sys_hold` falls.
- R5: While `kick_float` is high, the counter is held at zero, so with `supply_ok` high `wdog_n` stays high for any length of time. Counting resumes once `kick_float` falls.
- R6: When `supply_ok` is low, `wdog_n` is low in the same cycle, with no clock edge needed, whatever the timer state. When `supply_ok` returns high, `wdog_n` again shows the timer state.
- R7: A level on `kick_in` that lasts exactly one clock cycle is still detected and restarts the timeout.
- R8: After a timeout, `wdog_n` stays low while the counter is not cleared. A level change on `kick_in` clears it high after the SYNC_STAGES+1-th rising clock edge, counting the edge that first samples the new level. The output is still low after the edge before that.
- R9: Asserting `rst_n` low clears the counter and the synchronizer at once, so `wdog_n` equals `supply_ok` without a clock edge.
- R10: A timeout in progress is ended by `sys_hold`: `wdog_n` returns high after the first clock edge at which `sys_hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| sys_hold | input | 1 | High while the supervised system is held in reset |
| kick_in | input | 1 | Activity input from the processor, asynchronous |
| kick_float | input | 1 | High when the activity input is undriven |
| supply_ok | input | 1 | Supply-good flag from an external comparator |
| wdog_n | output | 1 | Watchdog alarm, active low |

## Verification
Several rules are checked by the assertions on every cycle:
- a low `supply_ok` always forces the alarm;
- a restart event, `sys_hold` or `kick_float` leaves the timer unexpired on the next cycle;
- an expired state persists until one of those clears it;
- an expiry only ever follows a count of one less than the limit.

Some behaviour can only be shown by the bench's scenarios:
- the exact cycle of the timeout;
- the synchronizer latency before a restart;
- a one-cycle pulse producing a restart;
- recovery of the output after supply and float episodes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Next counter value: cleared on request, otherwise counts up and
  // saturates at the limit.
  function automatic logic [31:0] wdt_step(input logic [31:0] cur,
                                           input logic        clr,
                                           input logic [31:0] lim);
    if (clr)             return 32'd0;
    else if (cur >= lim) return lim;
    else                 return cur + 32'd1;
  endfunction

  // Timed out once the counter has reached the limit.
  function automatic logic wdt_timed_out(input logic [31:0] cur,
                                         input logic [31:0] lim);
    return cur >= lim;
  endfunction

endpackage

// File: rtl/wdt_kick_detect.sv
module wdt_kick_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_in,
  output logic restart_evt
);
  // chain[0..SYNC_STAGES-1] form the synchronizer; chain[SYNC_STAGES]
  // holds the previous synchronized value for edge comparison.
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= kick_in;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  // Any level change, rising or falling.
  assign restart_evt = chain[SYNC_STAGES-1] ^ chain[SYNC_STAGES];

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int TIMEOUT_CYC = 80_000_000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  localparam logic [31:0] LIMIT = 32'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(wdt_pkg::wdt_step(32'(cnt), clr, LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign expired = wdt_pkg::wdt_timed_out(32'(cnt), LIMIT);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int TIMEOUT_CYC = 80_000_000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_hold,
  input  logic kick_in,
  input  logic kick_float,
  input  logic supply_ok,
  output logic wdog_n
);
  // Named internal events, exposed for the bound checker.
  logic             restart_evt;
  logic             hold_clr;
  logic             timer_clr;
  logic             expired;
  logic [CNT_W-1:0] cnt;

  wdt_kick_detect #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_in     (kick_in),
    .restart_evt (restart_evt)
  );

  assign hold_clr  = sys_hold | kick_float;
  assign timer_clr = hold_clr | restart_evt;

  wdt_timebase #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr),
    .cnt     (cnt),
    .expired (expired)
  );

  // Supply loss pulls the alarm without waiting for a clock edge.
  assign wdog_n = supply_ok & ~expired;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int TIMEOUT_CYC = 80_000_000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_hold,
  input logic             kick_float,
  input logic             supply_ok,
  input logic             wdog_n,
  input logic             restart_evt,
  input logic             expired,
  input logic [CNT_W-1:0] cnt
);
  p_early_expiry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> (32'($past(cnt)) == 32'(TIMEOUT_CYC - 1)));

  // Covers both edge polarities (R2, R3).
  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> !expired);

  p_hold_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hold |=> (!expired && wdog_n == supply_ok));

  p_float_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_float |=> !expired);

  p_supply_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wdog_n);

  p_expiry_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart_evt && !sys_hold && !kick_float) |=> expired);

endmodule

bind wdog_supervisor wdog_supervisor_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_hold    (sys_hold),
  .kick_float  (kick_float),
  .supply_ok   (supply_ok),
  .wdog_n      (wdog_n),
  .restart_evt (restart_evt),
  .expired     (expired),
  .cnt         (cnt)
);

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n, sys_hold, kick_in, kick_float, supply_ok;
  logic wdog_n;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wdog_supervisor #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) u_wdog_supervisor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_hold   (sys_hold),
    .kick_in    (kick_in),
    .kick_float (kick_float),
    .supply_ok  (supply_ok),
    .wdog_n     (wdog_n)
  );

  typedef struct packed {
    logic       hold;
    logic       flt;
    logic       kick;
    logic       sup;
    logic [7:0] cyc;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  1'b1, 4'd4},  // R4 held clear
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd19, 1'b1, 4'd1},  // R1 one short of limit
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd1},  // R1 limit reached
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  1'b0, 4'd8},  // R8 stays low
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd2,  1'b0, 4'd8},  // R8 still low in sync delay
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b1, 4'd2},  // R2 rising edge restarts
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd10, 1'b1, 4'd2},  // R2 counting again
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 4'd3},  // R3 falling edge clears
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd19, 1'b1, 4'd3},  // R3 restart proven
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd1},  // R1 timeout again
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  1'b1, 4'd10}, // R10 hold ends timeout
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 4'd6},  // R6 immediate low
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5,  1'b1, 4'd6},  // R6 recovers
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd30, 1'b1, 4'd5},  // R5 float holds clear
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 4'd6},  // R6 low-line while float
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 4'd5},  // R5 high again
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd19, 1'b1, 4'd5},  // R5 resumes from zero
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd5},  // R5 then times out
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 4'd6},  // R6 low while expired
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd0,  1'b0, 4'd8}   // R8 timeout still held
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (wdog_n !== exp) begin
      errors++;
      $display("FAIL R%0d %s: wdog_n=%b expected %b", req, what, wdog_n, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; sys_hold = 1'b1; kick_in = 1'b0;
    kick_float = 1'b0; supply_ok = 1'b1;
    tick(3);
    check(1'b1, 9, "reset state");  // R9
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sys_hold   = VECS[i].hold;
      kick_float = VECS[i].flt;
      kick_in    = VECS[i].kick;
      supply_ok  = VECS[i].sup;
      tick(int'(VECS[i].cyc));
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R7: one-cycle pulse on kick_in while timed out
    kick_in = 1'b1;
    tick(1);
    kick_in = 1'b0;
    tick(1);
    check(1'b0, 7, "pulse still in synchronizer");
    tick(1);
    check(1'b1, 7, "one-cycle pulse restarts");
    tick(TO);
    check(1'b1, 7, "second edge of pulse restarted again");
    tick(1);
    check(1'b0, 7, "timeout after pulse");

    // R4: long hold beyond the timeout
    sys_hold = 1'b1;
    tick(3 * TO);
    check(1'b1, 4, "long hold never expires");
    sys_hold = 1'b0;
    tick(TO - 1);
    check(1'b1, 4, "count from zero after hold");
    tick(1);
    check(1'b0, 4, "expires after hold release");

    // R9: asynchronous reset while timed out
    rst_n = 1'b0;
    #1;
    check(1'b1, 9, "async reset clears alarm");
    tick(1);
    rst_n = 1'b1;
    tick(2);
    check(1'b1, 9, "counting after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule